// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Controller

This block sits between a synchronous on-chip request port and an external, fully asynchronous parallel ROM that can be read either sixteen bits or eight bits at a time. A single request carries an address and a width flag. The controller sets the ROM's organization pin, drives the word address and opens the chip and output enables. In byte mode it also drives the least significant byte-address bit onto the top data pin, which the ROM then treats as an input. It then waits out the access timing as a whole number of clock cycles, registers the data lanes and returns them with a one-cycle valid strobe.

All timing is given in nanoseconds next to the clock period, and the cycle counts are derived by ceiling division. The chip enable stays low between reads once the first read is done. A later read in the same width pays only the address and output-enable delays. A read in the other width pays the full wait. After each capture the output enable is released, and no new request is taken until the float time has passed. This keeps the controller's own drive of the shared pin, and any other bus master, clear of the ROM's output drivers.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is high and after it is released with no request: `rom_ce_n`=1, `rom_oe_n`=1, `rom_a1_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A word read (`req_byte`=0) drives `rom_word`=1, `rom_addr`=`req_addr[21:0]` and `rom_a1_oe`=0, and returns all sixteen lanes of `rom_dq_in` on `rsp_data`.
- R3: A byte read (`req_byte`=1) drives `rom_word`=0, `rom_addr`=`req_addr[22:1]`, `rom_a1_out`=`req_addr[0]` and `rom_a1_oe`=1 for the whole access.
- R4: For a byte read, `rsp_data[7:0]` equals `rom_dq_in[7:0]` and `rsp_data[15:8]` is zero, whatever lanes 8 to 15 carry.
- R5: For the first read after reset, and for a read whose width differs from the previous one, `rsp_valid` is high after the Nth rising edge that follows the accepting edge. N = max(ceil(tAA/T), ceil(tACE/T), ceil(tOE/T)).
- R6: For a read in the same width as the previous one, `rom_ce_n` stays low between the reads, and N = max(ceil(tAA/T), ceil(tOE/T)).
- R7: From the accepting edge to the capture edge, `rom_addr`, `rom_word` and `rom_a1_out` do not change and `rom_oe_n` stays low.
- R8: `rom_oe_n` is high from the capture edge on. `req_ready` becomes high only after max(1, ceil(tDF/T)) further rising edges.
- R9: `req_valid` raised while `req_ready` is low is ignored: the access in flight keeps its pins and exactly one response is produced.
- R10: `rom_oe_n` is low only while `rom_ce_n` is low, and after reset `rom_ce_n` returns high only through reset.
- R11: `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 23 | Byte address (byte mode) or word address in bits 21:0 (word mode) |
| req_byte | input | 1 | 1 = byte-wide read, 0 = word-wide read |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 16 | Read data, upper byte zero for byte reads |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM organization select, 1 = word |
| rom_addr | output | 22 | ROM word address lines |
| rom_dq_in | input | 16 | ROM data lanes as seen by the controller |
| rom_a1_out | output | 1 | Value driven onto the shared top data pin in byte mode |
| rom_a1_oe | output | 1 | Drive enable for the shared top data pin |

## Verification
The hardest case to reach is a premature capture. A ROM model that simply returns data would hide a wait count that is one cycle short. So the bench model counts, on its own, how long the address, chip enable and output enable have each been settled. It returns a garbage pattern until all three windows are met. It also fills lanes 8 to 14 with junk in byte mode and decodes the byte from the shared pin only when the controller drives it. The stimulus then walks through cold reads, warm reads in both widths and width changes. It includes consecutive byte reads that differ only in the shared-pin bit, so the address timer must restart on that bit alone.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FLOAT = 2'd2
  } rd_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));  // R5

endmodule

// File: rtl/rom_rd_lanes.sv
module rom_rd_lanes #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] pins,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] data
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < BYTE_W) begin : g_low
      assign data[i] = pins[i];
    end else begin : g_high
      assign data[i] = pins[i] & ~byte_mode;
    end
  end

endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
  import rom_rd_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int WCW     = 4,
  parameter int FULL_LD = 9,
  parameter int WARM_LD = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte,
  input  logic              wait_done,
  input  logic              float_done,
  output logic              req_ready,
  output logic              wait_load,
  output logic [WCW-1:0]    wait_val,
  output logic              float_load,
  output logic              capture,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_word,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_a1_out,
  output logic              rom_a1_oe
);

  rd_state_e state;
  logic      accept;
  logic      warm;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign warm       = !rom_ce_n && (req_byte == !rom_word);
  assign wait_load  = accept;
  assign wait_val   = warm ? WCW'(WARM_LD) : WCW'(FULL_LD);
  assign capture    = (state == ST_WAIT) && wait_done;
  assign float_load = capture;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rom_ce_n   <= 1'b1;
      rom_oe_n   <= 1'b1;
      rom_word   <= 1'b1;
      rom_addr   <= '0;
      rom_a1_out <= 1'b0;
      rom_a1_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state      <= ST_WAIT;
            rom_ce_n   <= 1'b0;
            rom_oe_n   <= 1'b0;
            rom_word   <= !req_byte;
            rom_addr   <= req_byte ? req_addr[ADDR_W:1] : req_addr[ADDR_W-1:0];
            rom_a1_out <= req_byte & req_addr[0];
            rom_a1_oe  <= req_byte;
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            state    <= ST_FLOAT;
            rom_oe_n <= 1'b1;
          end
        end
        ST_FLOAT: begin
          if (float_done) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n);  // R10
  AST_CE_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
    !rom_ce_n |=> !rom_ce_n);  // R6
  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |=> ($stable(rom_addr) && $stable(rom_word) && $stable(rom_a1_out)));  // R7
  AST_OE_LOW_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !rom_oe_n);  // R7
  AST_BYTE_DRIVES_PIN: assert property (@(posedge clk) disable iff (rst)
    (!rom_word && !rom_ce_n) |-> rom_a1_oe);  // R3

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 100,
  parameter int T_ACE_NS      = 100,
  parameter int T_OE_NS       = 50,
  parameter int T_DF_NS       = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_word,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_dq_in,
  output logic              rom_a1_out,
  output logic              rom_a1_oe
);

  localparam int BYTE_W   = DATA_W / 2;
  localparam int AA_CYC   = imax(1, cdiv(T_AA_NS, CLK_PERIOD_NS));
  localparam int ACE_CYC  = imax(1, cdiv(T_ACE_NS, CLK_PERIOD_NS));
  localparam int OE_CYC   = imax(1, cdiv(T_OE_NS, CLK_PERIOD_NS));
  localparam int DF_CYC   = imax(1, cdiv(T_DF_NS, CLK_PERIOD_NS));
  localparam int FULL_CYC = imax(imax(AA_CYC, ACE_CYC), OE_CYC);
  localparam int WARM_CYC = imax(AA_CYC, OE_CYC);
  localparam int WCW      = $clog2(FULL_CYC + 1);
  localparam int FCW      = $clog2(DF_CYC + 1);

  logic              wait_load;
  logic [WCW-1:0]    wait_val;
  logic              wait_done;
  logic              float_load;
  logic              float_done;
  logic              capture;
  logic [DATA_W-1:0] lane_data;

  rom_rd_seq #(
    .ADDR_W  (ADDR_W),
    .WCW     (WCW),
    .FULL_LD (FULL_CYC - 1),
    .WARM_LD (WARM_CYC - 1)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_byte   (req_byte),
    .wait_done  (wait_done),
    .float_done (float_done),
    .req_ready  (req_ready),
    .wait_load  (wait_load),
    .wait_val   (wait_val),
    .float_load (float_load),
    .capture    (capture),
    .rom_ce_n   (rom_ce_n),
    .rom_oe_n   (rom_oe_n),
    .rom_word   (rom_word),
    .rom_addr   (rom_addr),
    .rom_a1_out (rom_a1_out),
    .rom_a1_oe  (rom_a1_oe)
  );

  rom_rd_timer #(.CW(WCW)) u_wait_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (wait_load),
    .load_val (wait_val),
    .done     (wait_done)
  );

  rom_rd_timer #(.CW(FCW)) u_float_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (float_load),
    .load_val (FCW'(DF_CYC - 1)),
    .done     (float_done)
  );

  rom_rd_lanes #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lanes (
    .pins      (rom_dq_in),
    .byte_mode (!rom_word),
    .data      (lane_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) begin
        rsp_data <= lane_data;
      end
    end
  end

  // Checker counters: cycles with output enable low, cycles since it rose.
  logic [WCW-1:0] chk_oe_low;
  logic [FCW-1:0] chk_oe_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_oe_low  <= '0;
      chk_oe_high <= FCW'(DF_CYC);
    end else begin
      if (rom_oe_n) begin
        chk_oe_low <= '0;
        if (chk_oe_high != FCW'(DF_CYC)) chk_oe_high <= chk_oe_high + 1'b1;
      end else begin
        chk_oe_high <= '0;
        if (chk_oe_low != WCW'(FULL_CYC)) chk_oe_low <= chk_oe_low + 1'b1;
      end
    end
  end

  AST_OE_WINDOW_MET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (chk_oe_low >= WCW'(OE_CYC)));  // R5
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (chk_oe_high >= FCW'(DF_CYC)));  // R8
  AST_OE_OFF_AT_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rom_oe_n);  // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);  // R11
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rom_word) |-> (rsp_data[DATA_W-1:BYTE_W] == '0));  // R4

endmodule

// File: tb/rom_rd_ctrl_tb.sv
module rom_rd_ctrl_tb;

  localparam int B_AA   = 6;
  localparam int B_ACE  = 10;
  localparam int B_OE   = 5;
  localparam int B_DF   = 2;
  localparam int B_FULL = 10;
  localparam int B_WARM = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rom_ce_n, rom_oe_n, rom_word, rom_a1_out, rom_a1_oe;
  logic [21:0] rom_addr;
  logic [15:0] rom_dq_in;

  always #5 clk = ~clk;

  rom_rd_ctrl #(
    .CLK_PERIOD_NS (10),
    .T_AA_NS       (60),
    .T_ACE_NS      (100),
    .T_OE_NS       (50),
    .T_DF_NS       (20)
  ) u_dut (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_byte (req_byte),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .rom_ce_n (rom_ce_n), .rom_oe_n (rom_oe_n), .rom_word (rom_word),
    .rom_addr (rom_addr), .rom_dq_in (rom_dq_in),
    .rom_a1_out (rom_a1_out), .rom_a1_oe (rom_a1_oe)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_at(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], 10'h2B5};
  endfunction

  function automatic logic [7:0] byte_at(input logic [22:0] ba);
    logic [15:0] w;
    w = word_at(ba[22:1]);
    return ba[0] ? w[15:8] : w[7:0];
  endfunction

  // ROM model: data only once all three windows are met.
  int ccnt = 0, ocnt = 0, acnt = 0;
  logic [23:0] last_pins = '0;
  logic rdy = 1'b0;

  always @(negedge clk) begin
    if (rom_ce_n) ccnt = 0; else ccnt = ccnt + 1;
    if (rom_oe_n) ocnt = 0; else ocnt = ocnt + 1;
    if ({rom_addr, rom_word, rom_a1_out} != last_pins) acnt = 1;
    else acnt = acnt + 1;
    last_pins = {rom_addr, rom_word, rom_a1_out};
    rdy = !rom_ce_n && !rom_oe_n && ccnt >= B_ACE && ocnt >= B_OE && acnt >= B_AA;
  end

  always_comb begin
    logic a1;
    a1 = rom_a1_oe ? rom_a1_out : 1'b1;
    if (!rdy) rom_dq_in = 16'hDEAD;
    else if (rom_word) rom_dq_in = word_at(rom_addr);
    else rom_dq_in = {a1, 7'h5A, byte_at({rom_addr, a1})};
  end

  typedef struct {
    logic [15:0] data;
    int          lat;
    int          acc;
    logic        is_byte;
    logic        cold;
  } exp_t;

  exp_t q[$];
  logic first = 1'b1;
  logic last_byte = 1'b0;

  // Monitor / scoreboard
  logic prev_rsp = 1'b0;
  logic flt_pend = 1'b0;
  int   flt_start = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_rsp = 1'b0;
      flt_pend = 1'b0;
    end else begin
      if (flt_pend && req_ready) begin
        chk(cyc - flt_start == B_DF, "R8 float gap", cyc - flt_start, B_DF);
        flt_pend = 1'b0;
      end
      if (rsp_valid) begin
        chk(!prev_rsp, "R11 pulse", 1, 0);
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_data == e.data, e.is_byte ? "R4 byte data" : "R2 word data",
              rsp_data, e.data);
          chk(cyc - e.acc == e.lat, e.cold ? "R5 cold latency" : "R6 warm latency",
              cyc - e.acc, e.lat);
        end
        chk(rom_oe_n, "R8 oe released", rom_oe_n, 1);
        flt_pend  = 1'b1;
        flt_start = cyc;
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic do_read(input logic [22:0] a, input logic bm);
    exp_t e;
    logic warm;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    warm      = !first && (bm == last_byte);
    e.lat     = warm ? B_WARM : B_FULL;
    e.cold    = !warm;
    e.is_byte = bm;
    e.data    = bm ? {8'h00, byte_at(a)} : word_at(a[21:0]);
    e.acc     = cyc + 1;
    q.push_back(e);
    req_valid = 1'b1;
    req_addr  = a;
    req_byte  = bm;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rom_ce_n && !rom_oe_n, "R10 enables active", {rom_ce_n, rom_oe_n}, 0);
    if (bm) begin
      chk(rom_word == 1'b0, "R3 mode pin", rom_word, 0);
      chk(rom_addr == a[22:1], "R3 address", rom_addr, a[22:1]);
      chk(rom_a1_oe && rom_a1_out == a[0], "R3 shared pin", {rom_a1_oe, rom_a1_out}, {1'b1, a[0]});
    end else begin
      chk(rom_word == 1'b1, "R2 mode pin", rom_word, 1);
      chk(rom_addr == a[21:0], "R2 address", rom_addr, a[21:0]);
      chk(!rom_a1_oe, "R2 pin released", rom_a1_oe, 0);
    end
    first     = 1'b0;
    last_byte = bm;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && !rom_a1_oe, "R1 pins in reset",
        {rom_ce_n, rom_oe_n, rom_a1_oe}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    chk(rom_ce_n && rom_oe_n && !rom_a1_oe, "R1 pins after reset",
        {rom_ce_n, rom_oe_n, rom_a1_oe}, 3'b110);
    chk(req_ready && !rsp_valid, "R1 handshake", {req_ready, rsp_valid}, 2'b10);
    first = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    do_read(23'h012345, 1'b0);          // R5 cold word
    do_read(23'h3FFFFF, 1'b0);          // R6 warm word
    drain();
    chk(!rom_ce_n, "R6 ce held low", rom_ce_n, 0);
    do_read(23'h7FFFFF, 1'b1);          // R5 mode change to byte, a1=1
    do_read(23'h0002A6, 1'b1);          // R6 warm byte, a1=0
    do_read(23'h0002A7, 1'b1);          // R6 only shared pin differs
    do_read(23'h000001, 1'b0);          // R5 back to word
    do_read(23'h0055AA, 1'b0);          // R6 warm, then R9 stray request
    req_valid = 1'b1;
    req_addr  = 23'h7ABCDE;
    req_byte  = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    chk(rom_addr == 22'h0055AA && rom_word, "R9 pins unchanged", rom_addr, 22'h0055AA);
    chk(!rom_oe_n, "R7 oe held low", rom_oe_n, 0);
    drain();
    chk(q.size() == 0, "R9 single response", q.size(), 0);
    do_reset();
    do_read(23'h1C0DE5, 1'b1);          // R5 cold byte after reset
    do_read(23'h000ABC, 1'b0);          // R5 mode change
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule